// File: doc/BRIEF.md
# SIMD Lane Averaging and Saturating ALU

This block is a wide vector datapath that treats its two operand vectors as a packed array of equal-width lanes (8, 16 or 32 bits each) and applies one arithmetic operation to every lane in parallel. It covers clamped addition and subtraction, halving average and halving difference, each with an optional round-up, in both signed and unsigned interpretations. All of these are evaluated at two bits wider than the lane, so no intermediate result can wrap before it is halved or clamped.

A separate select operation merges the two operands byte by byte under a predicate that carries one bit per byte. This gives predicated blends whose effect does not depend on the lane width. The result is captured in one output register, so each new operation appears one clock after its inputs.

Top module: `simd_avg_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes all zeros.
- R2: The result for inputs applied before a rising edge appears on `result` after that edge and not earlier.
- R3: `lane_sel` picks the lane width (0 = 8 bits, 1 = 16 bits, 2 = 32 bits). Lanes are packed little-endian, so lane k occupies bits [k*W +: W], and each lane is computed independently of the others.
- R4: `op_code` 0 gives a saturating add. The exact sum is clamped to [0, 2^W-1] when `signed_md` is 0 and to [-2^(W-1), 2^(W-1)-1] when it is 1.
- R5: `op_code` 1 gives a saturating subtract (a minus b), clamped to the same ranges as R4.
- R6: `op_code` 2 gives (a+b)>>1 and `op_code` 3 gives (a+b+1)>>1. Both are formed at double width, with zero extension when unsigned and sign extension plus an arithmetic shift when signed.
- R7: `op_code` 4 gives (a-b)>>1. The difference is taken at double width and shifted arithmetically, then only the low W bits are kept, with no clamping.
- R8: `op_code` 5 gives (a-b+1)>>1 at double width, clamped to the unsigned or signed lane range chosen by `signed_md`.
- R9: `op_code` 6 selects per byte: byte n of `result` is byte n of `opnd_a` when `pred[n]` is 1, and byte n of `opnd_b` otherwise. This holds for every legal `lane_sel` and either value of `signed_md`.
- R10: `op_code` 7, or `lane_sel` 3 with any opcode, produces an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | VEC_W | First operand vector |
| opnd_b | input | VEC_W | Second operand vector |
| lane_sel | input | 2 | Lane width code |
| op_code | input | 3 | Operation code |
| signed_md | input | 1 | 1 = signed lanes, 0 = unsigned |
| pred | input | VEC_W/8 | Byte predicate for select |
| result | output | VEC_W | Registered result vector |

## Verification
The byte-lane form of every arithmetic opcode is run over all 65536 operand pairs in both signednesses. This separates the clamp boundaries, the rounding increment, and the arithmetic and logical shifts on negative differences. The 16- and 32-bit lanes get a mix of random values and the edge values 0, 1, midpoint−1, midpoint, max−1 and max in every lane. These patterns catch carries that leak between lanes and clamps taken at the wrong width. The select is driven with random predicates under each width code, which shows that the mask is per byte rather than per lane. Illegal codes, mid-run reset and a check taken just before the clock edge cover the remaining requirements.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int N_WIDTHS = 3;
  localparam int BASE_LW  = 8;

  typedef enum logic [2:0] {
    OP_ADDS  = 3'd0,
    OP_SUBS  = 3'd1,
    OP_AVG   = 3'd2,
    OP_AVGR  = 3'd3,
    OP_DIFH  = 3'd4,
    OP_DIFHR = 3'd5,
    OP_SEL   = 3'd6,
    OP_BAD   = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LW_8   = 2'd0,
    LW_16  = 2'd1,
    LW_32  = 2'd2,
    LW_BAD = 2'd3
  } lane_w_e;
endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
  import simd_alu_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  alu_op_e       op,
  input  logic          sgn,
  output logic [LW-1:0] y
);
  localparam int EW = LW + 2;
  localparam logic signed [EW-1:0] SMAX = {3'b000, {(LW-1){1'b1}}};
  localparam logic signed [EW-1:0] SMIN = {3'b111, {(LW-1){1'b0}}};
  localparam logic signed [EW-1:0] UMAX = {2'b00, {LW{1'b1}}};

  logic signed [EW-1:0] xa, xb, sum, dif, rnd_v, avg, hdif;
  logic                 rnd_on;

  function automatic logic [LW-1:0] clamp(input logic signed [EW-1:0] v,
                                          input logic s);
    logic [LW-1:0] r;
    if (s) begin
      if (v > SMAX)      r = SMAX[LW-1:0];
      else if (v < SMIN) r = SMIN[LW-1:0];
      else               r = v[LW-1:0];
    end else begin
      if (v < 0)         r = '0;
      else if (v > UMAX) r = UMAX[LW-1:0];
      else               r = v[LW-1:0];
    end
    return r;
  endfunction

  always_comb begin
    xa     = {{2{a[LW-1] & sgn}}, a};
    xb     = {{2{b[LW-1] & sgn}}, b};
    sum    = xa + xb;
    dif    = xa - xb;
    rnd_on = (op == OP_AVGR) || (op == OP_DIFHR);
    rnd_v  = {{(EW-1){1'b0}}, rnd_on};
    avg    = (sum + rnd_v) >>> 1;
    hdif   = (dif + rnd_v) >>> 1;
    case (op)
      OP_ADDS:          y = clamp(sum, sgn);
      OP_SUBS:          y = clamp(dif, sgn);
      OP_AVG, OP_AVGR:  y = avg[LW-1:0];
      OP_DIFH:          y = hdif[LW-1:0];
      OP_DIFHR:         y = clamp(hdif, sgn);
      default:          y = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
  import simd_alu_pkg::*;
#(
  parameter int VEC_W = 1024,
  parameter int LW    = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  alu_op_e          op,
  input  logic             sgn,
  output logic [VEC_W-1:0] y
);
  localparam int N_LANES = VEC_W / LW;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    simd_lane_op #(.LW(LW)) u_lane (
      .a  (a[k*LW +: LW]),
      .b  (b[k*LW +: LW]),
      .op (op),
      .sgn(sgn),
      .y  (y[k*LW +: LW])
    );
  end
endmodule

// File: rtl/simd_byte_sel.sv
module simd_byte_sel #(
  parameter int VEC_W = 1024
) (
  input  logic [VEC_W-1:0]   a,
  input  logic [VEC_W-1:0]   b,
  input  logic [VEC_W/8-1:0] pred,
  output logic [VEC_W-1:0]   y
);
  localparam int N_BYTES = VEC_W / 8;

  for (genvar n = 0; n < N_BYTES; n++) begin : g_byte
    logic [7:0] keep;
    assign keep = {8{pred[n]}};
    assign y[n*8 +: 8] = (a[n*8 +: 8] & keep) | (b[n*8 +: 8] & ~keep);
  end
endmodule

// File: rtl/simd_avg_alu.sv
module simd_avg_alu
  import simd_alu_pkg::*;
#(
  parameter int VEC_W = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VEC_W-1:0]   opnd_a,
  input  logic [VEC_W-1:0]   opnd_b,
  input  logic [1:0]         lane_sel,
  input  logic [2:0]         op_code,
  input  logic               signed_md,
  input  logic [VEC_W/8-1:0] pred,
  output logic [VEC_W-1:0]   result
);
  alu_op_e          op;
  lane_w_e          lw_code;
  logic [VEC_W-1:0] bank_y [N_WIDTHS];
  logic [VEC_W-1:0] sel_y;
  logic [VEC_W-1:0] nxt;

  assign op      = alu_op_e'(op_code);
  assign lw_code = lane_w_e'(lane_sel);

  for (genvar gi = 0; gi < N_WIDTHS; gi++) begin : g_bank
    simd_lane_bank #(.VEC_W(VEC_W), .LW(BASE_LW << gi)) u_bank (
      .a  (opnd_a),
      .b  (opnd_b),
      .op (op),
      .sgn(signed_md),
      .y  (bank_y[gi])
    );
  end

  simd_byte_sel #(.VEC_W(VEC_W)) u_sel (
    .a   (opnd_a),
    .b   (opnd_b),
    .pred(pred),
    .y   (sel_y)
  );

  always_comb begin
    nxt = '0;
    if (lw_code != LW_BAD) begin
      case (op)
        OP_SEL:  nxt = sel_y;
        OP_BAD:  nxt = '0;
        default: nxt = bank_y[lane_sel];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= nxt;
  end
endmodule

// File: rtl/simd_avg_alu_chk.sv
module simd_avg_alu_chk #(
  parameter int VEC_W = 1024
) (
  input logic               clk,
  input logic               rst,
  input logic [VEC_W-1:0]   opnd_a,
  input logic [VEC_W-1:0]   opnd_b,
  input logic [1:0]         lane_sel,
  input logic [2:0]         op_code,
  input logic               signed_md,
  input logic [VEC_W/8-1:0] pred,
  input logic [VEC_W-1:0]   result
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> result == '0);

  // R10
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
    op_code == 3'd7 |=> result == '0);

  // R10
  bad_width_zero_chk: assert property (@(posedge clk) disable iff (rst)
    lane_sel == 2'd3 |=> result == '0);

  // R9
  sel_all_a_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd6 && lane_sel != 2'd3 && &pred) |=> result == $past(opnd_a));

  // R9
  sel_all_b_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd6 && lane_sel != 2'd3 && pred == '0) |=> result == $past(opnd_b));

  // R6
  avg_equal_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_code == 3'd2 || op_code == 3'd3) && lane_sel != 2'd3 && opnd_a == opnd_b)
    |=> result == $past(opnd_a));

  // R4
  add_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd0 && lane_sel != 2'd3 && !signed_md && opnd_b == '0)
    |=> result == $past(opnd_a));
endmodule

bind simd_avg_alu simd_avg_alu_chk #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .lane_sel (lane_sel),
  .op_code  (op_code),
  .signed_md(signed_md),
  .pred     (pred),
  .result   (result)
);

// File: tb/tb_simd_avg_alu.sv
module tb_simd_avg_alu;
  localparam int VW = 64;
  localparam int NB = VW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [VW-1:0] opnd_a = '0, opnd_b = '0;
  logic [1:0]    lane_sel = '0;
  logic [2:0]    op_code = '0;
  logic          signed_md = 1'b0;
  logic [NB-1:0] pred = '0;
  logic [VW-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  simd_avg_alu #(.VEC_W(VW)) dut (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .lane_sel(lane_sel), .op_code(op_code), .signed_md(signed_md),
    .pred(pred), .result(result)
  );

  function automatic longint sat_l(longint v, int lw, bit sg);
    longint hi, lo;
    if (sg) begin
      hi = (longint'(1) << (lw - 1)) - 1;
      lo = -(longint'(1) << (lw - 1));
    end else begin
      hi = (longint'(1) << lw) - 1;
      lo = 0;
    end
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint ref_lane(int lw, int op, bit sg, longint a, longint b);
    longint m, ea, eb, s, d, r;
    m  = (longint'(1) << lw) - 1;
    ea = a;
    eb = b;
    if (sg && a[lw-1]) ea = a - (longint'(1) << lw);
    if (sg && b[lw-1]) eb = b - (longint'(1) << lw);
    s = ea + eb;
    d = ea - eb;
    case (op)
      0: r = sat_l(s, lw, sg);
      1: r = sat_l(d, lw, sg);
      2: r = s >>> 1;
      3: r = (s + 1) >>> 1;
      4: r = d >>> 1;
      5: r = sat_l((d + 1) >>> 1, lw, sg);
      default: r = 0;
    endcase
    return r & m;
  endfunction

  function automatic logic [VW-1:0] ref_vec(int op, int ws, bit sg,
      logic [VW-1:0] a, logic [VW-1:0] b, logic [NB-1:0] p);
    logic [VW-1:0] y;
    int lw;
    y = '0;
    if (ws == 3 || op == 7) return y;
    if (op == 6) begin
      for (int n = 0; n < NB; n++)
        y[n*8 +: 8] = p[n] ? a[n*8 +: 8] : b[n*8 +: 8];
      return y;
    end
    lw = 8 << ws;
    for (int k = 0; k < VW / lw; k++) begin
      longint la, lb, r;
      la = 0;
      lb = 0;
      for (int i = 0; i < lw; i++) begin
        la[i] = a[k*lw + i];
        lb[i] = b[k*lw + i];
      end
      r = ref_lane(lw, op, sg, la, lb);
      for (int i = 0; i < lw; i++) y[k*lw + i] = r[i];
    end
    return y;
  endfunction

  function automatic string tag_of(int op, int ws);
    if (ws == 3 || op == 7) return "R10";
    case (op)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [VW-1:0] got, logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d w=%0d s=%0b got=%h exp=%h",
               tag, op_code, lane_sel, signed_md, got, exp);
    end
  endtask

  // Called at a falling edge; drives, waits one rising edge, checks at next falling edge.
  task automatic run(int op, int ws, bit sg, logic [VW-1:0] a, logic [VW-1:0] b,
                     logic [NB-1:0] p, string tag);
    logic [VW-1:0] exp;
    exp = ref_vec(op, ws, sg, a, b, p);
    op_code = 3'(op); lane_sel = 2'(ws); signed_md = sg;
    opnd_a = a; opnd_b = b; pred = p;
    @(negedge clk);
    check(tag, result, exp);
  endtask

  function automatic longint pick(int lw);
    longint half, m;
    int r;
    m    = (longint'(1) << lw) - 1;
    half = longint'(1) << (lw - 1);
    r    = int'($urandom % 10);
    case (r)
      0: return 0;
      1: return 1;
      2: return half - 1;
      3: return half;
      4: return m - 1;
      5: return m;
      default: return longint'({$urandom, $urandom}) & m;
    endcase
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [VW-1:0] va, vb, prev;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", result, '0);
    rst = 1'b0;

    // R3: lane packing, lane 0 in the low bits
    run(0, 1, 0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0004, '0, "R3");
    run(0, 0, 0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_10FF, '0, "R3");
    run(0, 2, 1, 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, '0, "R3");

    // R2: new inputs have no effect before the next rising edge
    prev = result;
    op_code = 3'd0; lane_sel = 2'd0; signed_md = 1'b0;
    opnd_a = 64'h1111_1111_1111_1111; opnd_b = 64'h2222_2222_2222_2222;
    #2;
    check("R2", result, prev);
    @(negedge clk);
    check("R2", result, 64'h3333_3333_3333_3333);

    // Exhaustive byte-lane sweep, all opcodes with arithmetic, both signedness
    for (int op = 0; op < 6; op++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int v = 0; v < 8192; v++) begin
          for (int k = 0; k < 8; k++) begin
            int pr;
            pr = v * 8 + k;
            va[k*8 +: 8] = 8'(pr >> 8);
            vb[k*8 +: 8] = 8'(pr);
          end
          run(op, 0, sg[0], va, vb, '0, tag_of(op, 0));
        end
      end
    end

    // 16- and 32-bit lanes: edge values mixed with random values
    for (int ws = 1; ws < 3; ws++) begin
      for (int op = 0; op < 6; op++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int t = 0; t < 200; t++) begin
            int lw;
            lw = 8 << ws;
            for (int k = 0; k < VW / lw; k++) begin
              longint x, y;
              x = pick(lw);
              y = pick(lw);
              for (int i = 0; i < lw; i++) begin
                va[k*lw + i] = x[i];
                vb[k*lw + i] = y[i];
              end
            end
            run(op, ws, sg[0], va, vb, '0, tag_of(op, ws));
          end
        end
      end
    end

    // R9: byte select under every legal width code and signedness
    for (int ws = 0; ws < 3; ws++)
      for (int t = 0; t < 100; t++)
        run(6, ws, t[0], {$urandom, $urandom}, {$urandom, $urandom},
            NB'($urandom), "R9");
    run(6, 2, 1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 8'b0101_1010, "R9");

    // R10: illegal opcode and illegal width code
    for (int t = 0; t < 40; t++) begin
      run(7, t % 3, t[0], {$urandom, $urandom}, {$urandom, $urandom}, NB'($urandom), "R10");
      run(t % 7, 3, t[1], {$urandom, $urandom}, {$urandom, $urandom}, NB'($urandom), "R10");
    end

    // R1: reset in the middle of operation
    run(0, 0, 0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, '0, "R4");
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, '0);
    rst = 1'b0;

    finish_run();
  end
endmodule